// File: doc/BRIEF.md
# Interrupt Flag and Vector Generator

This block sits between the message buffers of a CAN message controller and the CPU interrupt bus. Each of the sixteen message buffers has an event flag. The flag sets whenever that buffer finishes a transmission or a reception. A per-buffer mask bit decides whether a set flag may raise a request. Three status conditions also take part: bus-off, error and wake-up. Each arrives already gated by its own status logic and has its own enable bit. Together these make nineteen possible sources.

A programmed level selects one of seven active-high request lines. The block drives that line while any enabled source is pending. When the CPU runs an acknowledge cycle at that level, the block asks to take part in arbitration. If it wins, it returns an 8-bit vector. The vector holds a programmable 3-bit base followed by a 5-bit code for the highest-priority pending source.

Software clears a flag in two steps. It reads the flag register while the flag is set, then writes a zero to that bit. A new event on the buffer between those two accesses cancels the clear.

Top module: `can_irq_vecgen`

## Requirements
- R1: A one-cycle pulse on `buf_done_i[i]` sets flag bit i at the next clock edge. Transmit and receive completions use the same strobe. The flag register is read at `reg_addr_i` = 0 and occupies bits [15:0].
- R2: Writing 0 to a set flag bit clears it only if a read of the flag register while that bit was set came first. A zero write with no such read leaves the flag set.
- R3: Writing 1 to a flag bit never changes it. If a buffer event and a clearing write fall in the same cycle, the flag stays set.
- R4: An event on a buffer after the read and before the zero write cancels the read. The flag survives that write, and a fresh read is needed before a clear can succeed.
- R5: A buffer flag counts as pending only while its mask bit is 1. The mask register is at address 1, bits [15:0]. A status input counts as pending only while its enable bit is 1. The enables sit in the configuration register at address 2: bit 8 for bus-off, bit 9 for error, bit 10 for wake-up.
- R6: The level field is configuration bits [2:0]. With level L in 1..7 and any source pending, exactly `irq_o[L]` is 1. With L = 0, or with nothing pending, every request line is 0.
- R7: Priority is fixed: bus-off, then error, then wake-up, then buffers 0 to 15 in ascending order. The codes are 0, 1 and 2 for the three status sources and 3+i for buffer i.
- R8: `arb_req_o` is 1 when `iack_valid_i` is high, `iack_level_i` equals a nonzero level and a source is pending. `vec_valid_o` additionally requires `arb_win_i`. `vec_o` is then {configuration bits [6:4], 5-bit code}.
- R9: After reset, all flags, masks and configuration bits are 0, and no request line is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| buf_done_i | input | 16 | Per-buffer completion strobes |
| bus_off_i | input | 1 | Bus-off condition pending |
| err_i | input | 1 | Error condition pending |
| wake_i | input | 1 | Wake-up condition pending |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 flags, 1 mask, 2 configuration |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data (combinational) |
| irq_o | output | 7 | Request lines for levels 7 down to 1 |
| iack_valid_i | input | 1 | Acknowledge cycle in progress |
| iack_level_i | input | 3 | Level being acknowledged |
| arb_win_i | input | 1 | This block won arbitration |
| arb_req_o | output | 1 | Block takes part in arbitration |
| vec_valid_o | output | 1 | Vector is being driven |
| vec_o | output | 8 | Interrupt vector |

## Verification
The bench targets the clearing protocol. A zero write with no prior read must not clear a flag. A design that ignored the read would drop flags that software never saw. An event that lands between the read and the write, or in the same cycle as the write, must keep the flag. A design that let the clear win would lose a completion silently. The bench then walks the priority chain one source at a time and compares every vector code. It also checks level 0 and an acknowledge at the wrong level, where a faulty decoder would raise a stray request line or answer a cycle meant for another module.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
   localparam int unsigned NUM_STAT   = 3;
   localparam int unsigned ADDR_W     = 2;
   localparam logic [1:0]  A_FLAGS    = 2'd0;
   localparam logic [1:0]  A_MASK     = 2'd1;
   localparam logic [1:0]  A_CFG      = 2'd2;
   localparam int unsigned CFG_LVL_LO = 0;
   localparam int unsigned CFG_BASE_LO = 4;
   localparam int unsigned CFG_EN_LO  = 8;

   typedef enum logic [1:0] {
      SRC_BUSOFF = 2'd0,
      SRC_ERR    = 2'd1,
      SRC_WAKE   = 2'd2
   } stat_src_e;
endpackage

// File: rtl/can_irq_flag_bank.sv
module can_irq_flag_bank #(
   parameter int unsigned NUM_BUF = 16
) (
   input  logic               clk_i,
   input  logic               rst_n_i,
   input  logic [NUM_BUF-1:0] evt_i,
   input  logic               rd_hit_i,
   input  logic               wr_hit_i,
   input  logic [NUM_BUF-1:0] wdata_i,
   output logic [NUM_BUF-1:0] flag_o
);
   logic [NUM_BUF-1:0] flag_q;
   logic [NUM_BUF-1:0] armed_q;

   for (genvar i = 0; i < NUM_BUF; i++) begin : g_cell
      logic clr_ok;
      assign clr_ok = wr_hit_i & ~wdata_i[i] & armed_q[i];

      always_ff @(posedge clk_i or negedge rst_n_i) begin
         if (!rst_n_i) begin
            flag_q[i]  <= 1'b0;
            armed_q[i] <= 1'b0;
         end else begin
            if (evt_i[i])    flag_q[i] <= 1'b1;
            else if (clr_ok) flag_q[i] <= 1'b0;

            if (evt_i[i])                  armed_q[i] <= 1'b0;
            else if (wr_hit_i)             armed_q[i] <= 1'b0;
            else if (rd_hit_i && flag_q[i]) armed_q[i] <= 1'b1;
         end
      end
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/can_irq_prio_enc.sv
module can_irq_prio_enc #(
   parameter int unsigned NUM_SRC = 19,
   parameter int unsigned CODE_W  = 5
) (
   input  logic [NUM_SRC-1:0] req_i,
   output logic               hit_o,
   output logic [CODE_W-1:0]  code_o
);
   always_comb begin
      hit_o  = 1'b0;
      code_o = '0;
      for (int k = NUM_SRC - 1; k >= 0; k--) begin
         if (req_i[k]) begin
            hit_o  = 1'b1;
            code_o = CODE_W'(k);
         end
      end
   end
endmodule

// File: rtl/can_irq_req_ctrl.sv
module can_irq_req_ctrl #(
   parameter int unsigned LEVEL_W = 3,
   parameter int unsigned BASE_W  = 3,
   parameter int unsigned CODE_W  = 5,
   localparam int unsigned NUM_LVL = (1 << LEVEL_W) - 1,
   localparam int unsigned VEC_W   = BASE_W + CODE_W
) (
   input  logic               pend_i,
   input  logic [CODE_W-1:0]  code_i,
   input  logic [LEVEL_W-1:0] level_i,
   input  logic [BASE_W-1:0]  base_i,
   input  logic               iack_valid_i,
   input  logic [LEVEL_W-1:0] iack_level_i,
   input  logic               arb_win_i,
   output logic [NUM_LVL:1]   irq_o,
   output logic               arb_req_o,
   output logic               vec_valid_o,
   output logic [VEC_W-1:0]   vec_o
);
   logic active;
   assign active = pend_i & (level_i != '0);

   for (genvar l = 1; l <= NUM_LVL; l++) begin : g_line
      assign irq_o[l] = active & (level_i == LEVEL_W'(l));
   end

   assign arb_req_o   = active & iack_valid_i & (iack_level_i == level_i);
   assign vec_valid_o = arb_req_o & arb_win_i;
   assign vec_o       = vec_valid_o ? {base_i, code_i} : '0;
endmodule

// File: rtl/can_irq_vecgen.sv
module can_irq_vecgen
   import can_irq_pkg::*;
#(
   parameter int unsigned NUM_BUF = 16,
   parameter int unsigned LEVEL_W = 3,
   parameter int unsigned BASE_W  = 3,
   parameter int unsigned CODE_W  = 5,
   parameter int unsigned DATA_W  = 16,
   localparam int unsigned NUM_SRC = NUM_BUF + NUM_STAT,
   localparam int unsigned NUM_LVL = (1 << LEVEL_W) - 1,
   localparam int unsigned VEC_W   = BASE_W + CODE_W
) (
   input  logic               clk_i,
   input  logic               rst_n_i,
   input  logic [NUM_BUF-1:0] buf_done_i,
   input  logic               bus_off_i,
   input  logic               err_i,
   input  logic               wake_i,
   input  logic               reg_rd_i,
   input  logic               reg_wr_i,
   input  logic [ADDR_W-1:0]  reg_addr_i,
   input  logic [DATA_W-1:0]  reg_wdata_i,
   output logic [DATA_W-1:0]  reg_rdata_o,
   output logic [NUM_LVL:1]   irq_o,
   input  logic               iack_valid_i,
   input  logic [LEVEL_W-1:0] iack_level_i,
   input  logic               arb_win_i,
   output logic               arb_req_o,
   output logic               vec_valid_o,
   output logic [VEC_W-1:0]   vec_o
);
   if (NUM_SRC > (1 << CODE_W)) begin : g_bad_code
      $error("CODE_W too narrow for the number of sources");
   end
   if (DATA_W < NUM_BUF || DATA_W < CFG_EN_LO + NUM_STAT) begin : g_bad_data
      $error("DATA_W too narrow for the register fields");
   end
   if (CFG_BASE_LO + BASE_W > CFG_EN_LO || LEVEL_W > CFG_BASE_LO) begin : g_bad_fields
      $error("configuration fields overlap");
   end

   logic [NUM_BUF-1:0] flag_q;
   logic [NUM_BUF-1:0] mask_q;
   logic [DATA_W-1:0]  cfg_q;
   logic               flag_rd_hit;
   logic               flag_wr_hit;
   logic [NUM_SRC-1:0] src_req;
   logic               any_pend;
   logic [CODE_W-1:0]  win_code;
   logic [LEVEL_W-1:0] cfg_level;
   logic [BASE_W-1:0]  cfg_base;
   logic [NUM_STAT-1:0] cfg_en;

   assign flag_rd_hit = reg_rd_i & (reg_addr_i == A_FLAGS);
   assign flag_wr_hit = reg_wr_i & (reg_addr_i == A_FLAGS);

   assign cfg_level = cfg_q[CFG_LVL_LO +: LEVEL_W];
   assign cfg_base  = cfg_q[CFG_BASE_LO +: BASE_W];
   assign cfg_en    = cfg_q[CFG_EN_LO +: NUM_STAT];

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         mask_q <= '0;
         cfg_q  <= '0;
      end else if (reg_wr_i) begin
         if (reg_addr_i == A_MASK) mask_q <= reg_wdata_i[NUM_BUF-1:0];
         if (reg_addr_i == A_CFG)  cfg_q  <= reg_wdata_i;
      end
   end

   always_comb begin
      reg_rdata_o = '0;
      case (reg_addr_i)
         A_FLAGS: reg_rdata_o[NUM_BUF-1:0] = flag_q;
         A_MASK:  reg_rdata_o[NUM_BUF-1:0] = mask_q;
         A_CFG:   reg_rdata_o = cfg_q;
         default: reg_rdata_o = '0;
      endcase
   end

   can_irq_flag_bank #(.NUM_BUF(NUM_BUF)) u_flags (
      .clk_i    (clk_i),
      .rst_n_i  (rst_n_i),
      .evt_i    (buf_done_i),
      .rd_hit_i (flag_rd_hit),
      .wr_hit_i (flag_wr_hit),
      .wdata_i  (reg_wdata_i[NUM_BUF-1:0]),
      .flag_o   (flag_q)
   );

   assign src_req[SRC_BUSOFF] = bus_off_i & cfg_en[SRC_BUSOFF];
   assign src_req[SRC_ERR]    = err_i     & cfg_en[SRC_ERR];
   assign src_req[SRC_WAKE]   = wake_i    & cfg_en[SRC_WAKE];
   for (genvar b = 0; b < NUM_BUF; b++) begin : g_bufsrc
      assign src_req[NUM_STAT + b] = flag_q[b] & mask_q[b];
   end

   can_irq_prio_enc #(.NUM_SRC(NUM_SRC), .CODE_W(CODE_W)) u_enc (
      .req_i  (src_req),
      .hit_o  (any_pend),
      .code_o (win_code)
   );

   can_irq_req_ctrl #(.LEVEL_W(LEVEL_W), .BASE_W(BASE_W), .CODE_W(CODE_W)) u_req (
      .pend_i       (any_pend),
      .code_i       (win_code),
      .level_i      (cfg_level),
      .base_i       (cfg_base),
      .iack_valid_i (iack_valid_i),
      .iack_level_i (iack_level_i),
      .arb_win_i    (arb_win_i),
      .irq_o        (irq_o),
      .arb_req_o    (arb_req_o),
      .vec_valid_o  (vec_valid_o),
      .vec_o        (vec_o)
   );
endmodule

// File: rtl/can_irq_vecgen_chk.sv
module can_irq_vecgen_chk #(
   parameter int unsigned NUM_BUF = 16,
   parameter int unsigned NUM_SRC = 19,
   parameter int unsigned NUM_LVL = 7,
   parameter int unsigned LEVEL_W = 3,
   parameter int unsigned CODE_W  = 5,
   parameter int unsigned VEC_W   = 8
) (
   input logic               clk_i,
   input logic               rst_n_i,
   input logic [NUM_BUF-1:0] buf_done_i,
   input logic [NUM_BUF-1:0] flag_q,
   input logic               flag_wr_hit,
   input logic               any_pend,
   input logic [NUM_LVL:1]   irq_o,
   input logic [LEVEL_W-1:0] iack_level_i,
   input logic               arb_req_o,
   input logic               vec_valid_o,
   input logic [VEC_W-1:0]   vec_o
);
   // R1
   evt_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (|buf_done_i) |=> ((flag_q & $past(buf_done_i)) == $past(buf_done_i)));

   // R2
   flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !flag_wr_hit |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

   // R6
   one_line_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $onehot0(irq_o));

   // R6
   idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !any_pend |-> (irq_o == '0));

   // R8
   vec_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      vec_valid_o |-> (arb_req_o && iack_level_i != '0 && irq_o[iack_level_i]));

   // R7
   code_range_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      vec_valid_o |-> (vec_o[CODE_W-1:0] < CODE_W'(NUM_SRC)));
endmodule

bind can_irq_vecgen can_irq_vecgen_chk #(
   .NUM_BUF(NUM_BUF), .NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL),
   .LEVEL_W(LEVEL_W), .CODE_W(CODE_W), .VEC_W(VEC_W)
) u_chk (
   .clk_i        (clk_i),
   .rst_n_i      (rst_n_i),
   .buf_done_i   (buf_done_i),
   .flag_q       (flag_q),
   .flag_wr_hit  (flag_wr_hit),
   .any_pend     (any_pend),
   .irq_o        (irq_o),
   .iack_level_i (iack_level_i),
   .arb_req_o    (arb_req_o),
   .vec_valid_o  (vec_valid_o),
   .vec_o        (vec_o)
);

// File: tb/tb_can_irq_vecgen.sv
module tb_can_irq_vecgen;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] buf_done = '0;
   logic        bus_off = 1'b0, err = 1'b0, wake = 1'b0;
   logic        reg_rd = 1'b0, reg_wr = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [7:1]  irq;
   logic        iack_valid = 1'b0;
   logic [2:0]  iack_level = '0;
   logic        arb_win = 1'b0;
   logic        arb_req, vec_valid;
   logic [7:0]  vec;

   int n_chk = 0;
   int n_err = 0;

   always #(CLK_P/2) clk = ~clk;

   can_irq_vecgen dut (
      .clk_i(clk), .rst_n_i(rst_n), .buf_done_i(buf_done),
      .bus_off_i(bus_off), .err_i(err), .wake_i(wake),
      .reg_rd_i(reg_rd), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
      .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq),
      .iack_valid_i(iack_valid), .iack_level_i(iack_level), .arb_win_i(arb_win),
      .arb_req_o(arb_req), .vec_valid_o(vec_valid), .vec_o(vec)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 d = reg_rdata;
      @(negedge clk); reg_rd = 1'b0;
   endtask

   task automatic pulse(input logic [15:0] m);
      @(negedge clk); buf_done = m;
      @(negedge clk); buf_done = '0;
   endtask

   task automatic flush_flags();
      logic [15:0] d;
      rd(2'd0, d); wr(2'd0, 16'h0000);
   endtask

   task automatic ack(input logic [2:0] lvl, input logic win,
                      output logic req, output logic vv, output logic [7:0] v);
      @(negedge clk); iack_valid = 1'b1; iack_level = lvl; arb_win = win;
      #1 req = arb_req; vv = vec_valid; v = vec;
      @(negedge clk); iack_valid = 1'b0; arb_win = 1'b0;
   endtask

   task automatic t_reset();
      logic [15:0] d;
      #1 chk("R9 irq", 32'(irq), 0);
      rd(2'd0, d); chk("R9 flags", 32'(d), 0);
      rd(2'd1, d); chk("R9 mask", 32'(d), 0);
      rd(2'd2, d); chk("R9 cfg", 32'(d), 0);
   endtask

   task automatic t_set_clear();
      logic [15:0] d;
      wr(2'd2, 16'h0053);
      wr(2'd1, 16'hFFFF);
      pulse(16'h0010);
      #1 chk("R1 irq line 3", 32'(irq), 32'h04);
      wr(2'd0, 16'h0000);
      rd(2'd0, d); chk("R2 unread zero write ignored", 32'(d), 32'h0010);
      wr(2'd0, 16'h0000);
      rd(2'd0, d); chk("R2 read then zero clears", 32'(d), 0);
   endtask

   task automatic t_write_one();
      logic [15:0] d;
      pulse(16'h0004);
      rd(2'd0, d);
      wr(2'd0, 16'hFFFF);
      rd(2'd0, d); chk("R3 write one no effect", 32'(d), 32'h0004);
      @(negedge clk); reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h0000; buf_done = 16'h0004;
      @(negedge clk); reg_wr = 1'b0; buf_done = '0;
      rd(2'd0, d); chk("R3 event beats same-cycle clear", 32'(d), 32'h0004);
      flush_flags();
      rd(2'd0, d); chk("R3 cleanup", 32'(d), 0);
   endtask

   task automatic t_rearm();
      logic [15:0] d;
      pulse(16'h0080);
      rd(2'd0, d);
      pulse(16'h0080);
      wr(2'd0, 16'h0000);
      rd(2'd0, d); chk("R4 event between read and write keeps flag", 32'(d), 32'h0080);
      wr(2'd0, 16'h0000);
      rd(2'd0, d); chk("R4 fresh read then clear", 32'(d), 0);
   endtask

   task automatic t_mask();
      logic [15:0] d;
      wr(2'd1, 16'h0000);
      pulse(16'h0200);
      #1 chk("R5 masked buffer no request", 32'(irq), 0);
      rd(2'd0, d); chk("R5 flag still recorded", 32'(d), 32'h0200);
      wr(2'd1, 16'h0200);
      #1 chk("R5 unmask raises request", 32'(irq), 32'h04);
      flush_flags();
      @(negedge clk); wake = 1'b1;
      #1 chk("R5 wake disabled", 32'(irq), 0);
      wr(2'd2, 16'h0453);
      #1 chk("R5 wake enabled", 32'(irq), 32'h04);
      @(negedge clk); wake = 1'b0;
      #1 chk("R6 nothing pending quiet", 32'(irq), 0);
   endtask

   task automatic t_level();
      @(negedge clk); err = 1'b1;
      wr(2'd2, 16'h0250);
      #1 chk("R6 level zero quiet", 32'(irq), 0);
      wr(2'd2, 16'h0257);
      #1 chk("R6 level 7", 32'(irq), 32'h40);
      wr(2'd2, 16'h0251);
      #1 chk("R6 level 1", 32'(irq), 32'h01);
      @(negedge clk); err = 1'b0;
   endtask

   task automatic t_prio_ack();
      logic r, vv;
      logic [7:0] v;
      wr(2'd2, 16'h0753);
      wr(2'd1, 16'hFFFF);
      pulse(16'h8001);
      @(negedge clk); bus_off = 1'b1; err = 1'b1; wake = 1'b1;
      ack(3'd3, 1'b1, r, vv, v); chk("R7 bus-off first", 32'(v), 32'hA0);
      @(negedge clk); bus_off = 1'b0;
      ack(3'd3, 1'b1, r, vv, v); chk("R7 error second", 32'(v), 32'hA1);
      @(negedge clk); err = 1'b0;
      ack(3'd3, 1'b1, r, vv, v); chk("R7 wake third", 32'(v), 32'hA2);
      @(negedge clk); wake = 1'b0;
      ack(3'd3, 1'b1, r, vv, v); chk("R7 buffer 0 code 3", 32'(v), 32'hA3);
      chk("R8 vec valid on win", 32'(vv), 1);
      begin
         logic [15:0] d;
         rd(2'd0, d); wr(2'd0, 16'h8000);
      end
      ack(3'd3, 1'b1, r, vv, v); chk("R7 buffer 15 code 18", 32'(v), 32'hB2);
      ack(3'd2, 1'b1, r, vv, v);
      chk("R8 wrong level no arb", 32'(r), 0);
      chk("R8 wrong level no vector", 32'(vv), 0);
      ack(3'd3, 1'b0, r, vv, v);
      chk("R8 lost arbitration arb_req", 32'(r), 1);
      chk("R8 lost arbitration no vector", 32'(vv), 0);
      flush_flags();
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            t_reset();
            t_set_clear();
            t_write_one();
            t_rearm();
            t_mask();
            t_level();
            t_prio_ack();
         end
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_err++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      disable fork;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule